// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block runs on the reference clock. It produces a signed frequency-deviation word for a fractional-N feedback divider. The deviation follows a linear triangle centred on zero, so the synthesized clock swings equally above and below the reference frequency. The sweep period is a fixed number of reference cycles, 1152 by default. The modulation rate therefore scales with the reference frequency: a 40 MHz reference gives about 34.7 kHz.

The peak deviation is chosen by a 2-bit spread-range code. The output unit is 0.01 %, so a word of 100 means +1.00 %. A new code takes effect only when the profile passes through zero, which keeps the deviation free of jumps. An active-low enable runs the sweep. While the enable is high, the output holds zero and the sweep phase is parked at its start.

Steps are generated with an exact integer-plus-remainder accumulator, so every segment lands exactly on its peak. Pins left floating default to range code 11 with modulation enabled; those pull resistors sit outside this block.

The deviation word is a continuous sample that is refreshed every reference cycle. It has no valid/ready handshake: the divider reads it on every cycle, and back-pressure cannot arise.

Top module: `ssc_profile_gen`

## Requirements
- R1: The range code selects the peak magnitude in units of 0.01 %: code 2'b00 gives 150, 2'b01 gives 250, 2'b10 gives 50 and 2'b11 gives 100.
- R2: The profile is centre-symmetric. At enabled phase 864 the output equals the negative of the peak that was latched for the second half.
- R3: While enabled, the profile repeats every 1152 cycles. The output is zero at phases 0 and 576 and equals +peak at phase 288.
- R4: When spread_n is high at a clock edge, dev_out is zero after that edge and the sweep phase returns to 0.
- R5: After re-enable, the profile restarts from zero on the rising segment and reaches +peak 288 cycles after the first enabled edge.
- R6: At phase p, define t as p for p up to 288, 576 − p for p up to 864, and p − 1152 otherwise. The output is then sign(t)·floor(peak·|t|/288), with no drift across segments. Adjacent outputs therefore differ by at most 1.
- R7: The range code is sampled only at phases 0 and 576. A change made at any other phase has no effect until the next of those two phases.
- R8: A synchronous active-high reset returns the phase to 0 and forces dev_out to zero on the following cycle.
- R9: dev_out is never negative in the first half-period (phases 0 to 575) and never positive in the second half (phases 576 to 1151).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| range_sel | input | 2 | Spread-range code |
| spread_n | input | 1 | Active-low modulation enable |
| dev_out | output | 10 | Signed deviation in 0.01 % units (two's complement) |

## Verification
The assertions assume that spread_n and range_sel are synchronous to the reference clock and settle well before each edge. They also assume that reset is held over the first edge. Under those assumptions, a mirror phase count in the checker tracks the design's phase exactly. The bench changes every input one time unit after an edge and holds reset high from time zero. It sweeps all four range codes through full periods and compares every cycle against the closed-form triangle. It also makes range changes in the middle of a segment and disables the sweep, then re-enables it, at an arbitrary phase.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic [1:0] {
    SPR_MID    = 2'b00,
    SPR_WIDE   = 2'b01,
    SPR_NARROW = 2'b10,
    SPR_LOW    = 2'b11
  } spread_code_e;

  localparam int DEF_PERIOD = 1152;
  localparam int DEF_DEV_W  = 10;
  localparam int DEF_PK_MID    = 150;
  localparam int DEF_PK_WIDE   = 250;
  localparam int DEF_PK_NARROW = 50;
  localparam int DEF_PK_LOW    = 100;
endpackage

// File: rtl/ssc_range_decode.sv
module ssc_range_decode
  import ssc_pkg::*;
#(
  parameter int PK_MID    = DEF_PK_MID,
  parameter int PK_WIDE   = DEF_PK_WIDE,
  parameter int PK_NARROW = DEF_PK_NARROW,
  parameter int PK_LOW    = DEF_PK_LOW,
  parameter int QUARTER   = DEF_PERIOD / 4,
  parameter int MAG_W     = DEF_DEV_W - 1,
  parameter int REM_W     = $clog2(QUARTER)
) (
  input  logic [1:0]       sel,
  output logic [MAG_W-1:0] step_whole,
  output logic [REM_W-1:0] step_frac
);
  logic [MAG_W-1:0] whole_tab [4];
  logic [REM_W-1:0] frac_tab  [4];
  logic [1:0]       idx;

  // per-cycle step = peak / QUARTER, split into integer and remainder
  for (genvar i = 0; i < 4; i++) begin : g_ent
    localparam int PK = (i == 0) ? PK_MID : (i == 1) ? PK_WIDE :
                        (i == 2) ? PK_NARROW : PK_LOW;
    assign whole_tab[i] = MAG_W'(PK / QUARTER);
    assign frac_tab[i]  = REM_W'(PK % QUARTER);
  end

  always_comb begin
    unique case (spread_code_e'(sel))
      SPR_MID:    idx = 2'd0;
      SPR_WIDE:   idx = 2'd1;
      SPR_NARROW: idx = 2'd2;
      SPR_LOW:    idx = 2'd3;
      default:    idx = 2'd3;
    endcase
  end

  assign step_whole = whole_tab[idx];
  assign step_frac  = frac_tab[idx];
endmodule

// File: rtl/ssc_phase_ctr.sv
module ssc_phase_ctr #(
  parameter int PERIOD = 1152,
  parameter int PH_W   = $clog2(PERIOD)
) (
  input  logic            clk,
  input  logic            clr,
  output logic [PH_W-1:0] phase,
  output logic            mag_up,
  output logic            at_zero,
  output logic            neg_half
);
  localparam int QUARTER = PERIOD / 4;
  localparam int HALF    = PERIOD / 2;
  localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD - 1);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (clr)               ph_q <= '0;
    else if (ph_q == LAST) ph_q <= '0;
    else                   ph_q <= ph_q + 1'b1;
  end

  assign phase    = ph_q;
  // magnitude grows in the first and third quarters, shrinks elsewhere
  assign mag_up   = (ph_q < PH_W'(QUARTER)) ||
                    ((ph_q >= PH_W'(HALF)) && (ph_q < PH_W'(HALF + QUARTER)));
  assign at_zero  = (ph_q == '0) || (ph_q == PH_W'(HALF));
  assign neg_half = (ph_q >= PH_W'(HALF));
endmodule

// File: rtl/ssc_tri_accum.sv
module ssc_tri_accum #(
  parameter int QUARTER = 288,
  parameter int MAG_W   = 9,
  parameter int REM_W   = $clog2(QUARTER)
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             up,
  input  logic [MAG_W-1:0] step_whole,
  input  logic [REM_W-1:0] step_frac,
  output logic [MAG_W-1:0] mag
);
  localparam logic [REM_W:0] QV = (REM_W+1)'(QUARTER);

  logic [MAG_W-1:0] mag_q, mag_d;
  logic [REM_W-1:0] rem_q, rem_d;
  logic [REM_W:0]   sum_w, frac_w, rem_w;
  logic             carry;

  assign frac_w = {1'b0, step_frac};
  assign rem_w  = {1'b0, rem_q};

  // exact numerator peak*|t| held as mag*QUARTER + rem
  always_comb begin
    if (up) begin
      sum_w = rem_w + frac_w;
      carry = (sum_w >= QV);
      rem_d = carry ? REM_W'(sum_w - QV) : REM_W'(sum_w);
      mag_d = mag_q + step_whole + MAG_W'(carry);
    end else begin
      carry = (rem_w < frac_w);
      sum_w = carry ? (rem_w + QV - frac_w) : (rem_w - frac_w);
      rem_d = REM_W'(sum_w);
      mag_d = mag_q - step_whole - MAG_W'(carry);
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      mag_q <= '0;
      rem_q <= '0;
    end else begin
      mag_q <= mag_d;
      rem_q <= rem_d;
    end
  end

  assign mag = mag_q;
endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
  import ssc_pkg::*;
#(
  parameter int PERIOD    = DEF_PERIOD,
  parameter int DEV_W     = DEF_DEV_W,
  parameter int PK_MID    = DEF_PK_MID,
  parameter int PK_WIDE   = DEF_PK_WIDE,
  parameter int PK_NARROW = DEF_PK_NARROW,
  parameter int PK_LOW    = DEF_PK_LOW
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              range_sel,
  input  logic                    spread_n,
  output logic signed [DEV_W-1:0] dev_out
);
  localparam int QUARTER = PERIOD / 4;
  localparam int MAG_W   = DEV_W - 1;
  localparam int REM_W   = $clog2(QUARTER);
  localparam int PH_W    = $clog2(PERIOD);

  logic             clr;
  logic [PH_W-1:0]  phase;
  logic             mag_up, at_zero, neg_half;
  logic [MAG_W-1:0] dec_whole, held_whole, use_whole, mag;
  logic [REM_W-1:0] dec_frac, held_frac, use_frac;
  logic signed [DEV_W-1:0] mag_s;

  assign clr = rst | spread_n;

  ssc_range_decode #(
    .PK_MID(PK_MID), .PK_WIDE(PK_WIDE), .PK_NARROW(PK_NARROW),
    .PK_LOW(PK_LOW), .QUARTER(QUARTER), .MAG_W(MAG_W), .REM_W(REM_W)
  ) dec_i (
    .sel(range_sel), .step_whole(dec_whole), .step_frac(dec_frac)
  );

  ssc_phase_ctr #(.PERIOD(PERIOD), .PH_W(PH_W)) ph_i (
    .clk(clk), .clr(clr), .phase(phase), .mag_up(mag_up),
    .at_zero(at_zero), .neg_half(neg_half)
  );

  // range is only re-sampled while the profile sits at zero
  assign use_whole = at_zero ? dec_whole : held_whole;
  assign use_frac  = at_zero ? dec_frac  : held_frac;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_whole <= '0;
      held_frac  <= '0;
    end else begin
      held_whole <= use_whole;
      held_frac  <= use_frac;
    end
  end

  ssc_tri_accum #(.QUARTER(QUARTER), .MAG_W(MAG_W), .REM_W(REM_W)) acc_i (
    .clk(clk), .clr(clr), .up(mag_up), .step_whole(use_whole),
    .step_frac(use_frac), .mag(mag)
  );

  assign mag_s   = $signed({1'b0, mag});
  assign dev_out = neg_half ? -mag_s : mag_s;

  logic unused_ph;
  assign unused_ph = ^phase;
endmodule

// File: rtl/ssc_profile_chk.sv
module ssc_profile_chk #(
  parameter int PERIOD    = 1152,
  parameter int DEV_W     = 10,
  parameter int PK_MID    = 150,
  parameter int PK_WIDE   = 250,
  parameter int PK_NARROW = 50,
  parameter int PK_LOW    = 100
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    spread_n,
  input logic signed [DEV_W-1:0] dev_out
);
  localparam int Q    = PERIOD / 4;
  localparam int HALF = PERIOD / 2;
  localparam int MAXA = (PK_MID > PK_WIDE) ? PK_MID : PK_WIDE;
  localparam int MAXB = (PK_NARROW > PK_LOW) ? PK_NARROW : PK_LOW;
  localparam int MAXP = (MAXA > MAXB) ? MAXA : MAXB;
  localparam int MAX_STEP = (MAXP + Q - 1) / Q;
  localparam int CW = $clog2(PERIOD);

  logic [CW-1:0] cnt;
  int dv;
  assign dv = int'(dev_out);

  always_ff @(posedge clk) begin
    if (rst || spread_n)                  cnt <= '0;
    else if (cnt == CW'(PERIOD - 1))      cnt <= '0;
    else                                  cnt <= cnt + 1'b1;
  end

  a_r8_reset_zero: assert property (@(posedge clk) rst |=> dev_out == '0);

  a_r4_disable_zero: assert property (@(posedge clk) disable iff (rst)
    spread_n |=> dev_out == '0);

  a_r3_zero_points: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 || cnt == CW'(HALF)) |-> dev_out == '0);

  a_r1_quarter_peak: assert property (@(posedge clk) disable iff (rst)
    (cnt == CW'(Q)) |-> (dv == PK_MID || dv == PK_WIDE ||
                         dv == PK_NARROW || dv == PK_LOW));

  a_r9_first_half_nonneg: assert property (@(posedge clk) disable iff (rst)
    (cnt < CW'(HALF)) |-> dv >= 0);

  a_r9_second_half_nonpos: assert property (@(posedge clk) disable iff (rst)
    (cnt >= CW'(HALF)) |-> dv <= 0);

  a_r6_small_step: assert property (@(posedge clk) disable iff (rst)
    !spread_n |=> ((dv - int'($past(dev_out))) <= MAX_STEP) &&
                  ((dv - int'($past(dev_out))) >= -MAX_STEP));
endmodule

bind ssc_profile_gen ssc_profile_chk #(
  .PERIOD(PERIOD), .DEV_W(DEV_W), .PK_MID(PK_MID), .PK_WIDE(PK_WIDE),
  .PK_NARROW(PK_NARROW), .PK_LOW(PK_LOW)
) chk_i (
  .clk(clk), .rst(rst), .spread_n(spread_n), .dev_out(dev_out)
);

// File: tb/ssc_profile_gen_tb.sv
module ssc_profile_gen_tb_top;
  localparam int P = 1152;
  localparam int Q = 288;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] range_sel = 2'b11;
  logic spread_n = 1'b0;
  logic signed [9:0] dev_out;

  int n_chk = 0;
  int n_err = 0;
  int p_m = 0;
  int seg_m = 0;

  always #2 clk = ~clk;

  ssc_profile_gen dut_i (
    .clk(clk), .rst(rst), .range_sel(range_sel),
    .spread_n(spread_n), .dev_out(dev_out)
  );

  function automatic int peak_of(logic [1:0] c);
    case (c)
      2'b00: return 150;
      2'b01: return 250;
      2'b10: return 50;
      default: return 100;
    endcase
  endfunction

  function automatic int expect_dev(int p, int pk);
    int t, m;
    if (p <= Q) t = p;
    else if (p <= 3*Q) t = 2*Q - p;
    else t = p - P;
    m = pk * (t < 0 ? -t : t) / Q;
    return (t < 0) ? -m : m;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // advance model and design one edge, then settle
  task automatic tick();
    if (rst || spread_n) p_m = 0;
    else begin
      if (p_m == 0 || p_m == 2*Q) seg_m = peak_of(range_sel);
      p_m = (p_m + 1) % P;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic tick_cmp(string tag);
    tick();
    chk(int'(dev_out) == expect_dev(p_m, seg_m), tag, int'(dev_out),
        expect_dev(p_m, seg_m));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #1;
    tick(); tick();
    chk(dev_out == 0, "R8 reset", int'(dev_out), 0);
    rst = 1'b0;

    // full sweeps of every range code
    for (int r = 0; r < 4; r++) begin
      rst = 1'b1; tick(); rst = 1'b0;
      range_sel = r[1:0];
      for (int k = 0; k < P; k++) begin
        tick_cmp("R6 profile");
        if (p_m == Q)
          chk(int'(dev_out) == peak_of(r[1:0]), "R1 peak", int'(dev_out), peak_of(r[1:0]));
        if (p_m == 3*Q)
          chk(int'(dev_out) == -peak_of(r[1:0]), "R2 neg peak", int'(dev_out), -peak_of(r[1:0]));
        if (p_m == 2*Q)
          chk(dev_out == 0, "R3 mid zero", int'(dev_out), 0);
        if (p_m > 0 && p_m < 2*Q)
          chk(int'(dev_out) >= 0, "R9 sign first", int'(dev_out), 0);
        if (p_m > 2*Q)
          chk(int'(dev_out) <= 0, "R9 sign second", int'(dev_out), 0);
      end
      chk(dev_out == 0, "R3 wrap zero", int'(dev_out), 0);
    end

    // range change mid-segment
    rst = 1'b1; tick(); rst = 1'b0;
    range_sel = 2'b11;
    for (int k = 0; k < 100; k++) tick_cmp("R7 pre");
    range_sel = 2'b01;
    for (int k = 0; k < 188; k++) tick_cmp("R7 hold");
    chk(int'(dev_out) == 100, "R7 old peak kept", int'(dev_out), 100);
    for (int k = 0; k < 576; k++) tick_cmp("R7 after zero");
    chk(int'(dev_out) == -250, "R7 new peak at zero crossing", int'(dev_out), -250);

    // disable mid-sweep and re-enable
    for (int k = 0; k < 100; k++) tick_cmp("R4 pre");
    spread_n = 1'b1;
    tick();
    chk(dev_out == 0, "R4 disable", int'(dev_out), 0);
    range_sel = 2'b00;
    for (int k = 0; k < 5; k++) begin
      tick();
      chk(dev_out == 0, "R4 held", int'(dev_out), 0);
    end
    spread_n = 1'b0;
    for (int k = 0; k < Q; k++) begin
      tick_cmp("R5 restart");
      if (k == 0) chk(int'(dev_out) >= 0, "R5 rising", int'(dev_out), 0);
    end
    chk(int'(dev_out) == 150, "R5 peak", int'(dev_out), 150);

    // reset mid-sweep
    for (int k = 0; k < 50; k++) tick_cmp("R8 pre");
    rst = 1'b1;
    tick();
    chk(dev_out == 0, "R8 mid reset", int'(dev_out), 0);
    rst = 1'b0;
    for (int k = 0; k < 20; k++) tick_cmp("R8 after");

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule